// File: doc/BRIEF.md
# Nine-Bit Serial Display Panel Link

This block is a serial master for a display panel controller that takes 9-bit words on one shared data line. The top bit of every word tells the panel how to read the low byte: cleared means the byte is an opcode, set means it is an argument of the last opcode. A host supplies one request at a time through a valid/ready handshake. A write request carries a flag and a byte, and the block sends them as a single word.

An identification read request carries the read opcode. The block sends that opcode as a command word and then releases the data line. It clocks one 9-bit word whose received bits are thrown away, and then clocks an 8-bit word. The byte taken from that last word is returned with a one-cycle response strobe.

The serial clock idles low. Outgoing bits change only while the clock is low, and incoming bits are taken on the rising edge. Chip select frames each word on its own. The half period of the serial clock is derived from two frequency parameters.

Top module: `panel9_link`

## Requirements
- R1: A command word has bit 8 (the first bit sent) equal to 0 and carries the opcode in bits 7:0. The opcode of an identification read is always sent as a command word, whatever the parameter flag says.
- R2: A write request with `req_param`=1 produces a word with bit 8 equal to 1 and the byte in bits 7:0. This is the byte ORed with 0x100.
- R3: Every word is sent most significant bit first. A write word has exactly 9 rising clock edges inside its chip-select window.
- R4: The serial clock is low whenever chip select is high. `lcd_sda_out` never changes while `lcd_sclk` stays high.
- R5: `lcd_cs_n` is low for each word on its own. The first rising clock edge comes one half period after chip select falls. Chip select rises one half period after the last falling clock edge. Between two words chip select stays high for at least one half period.
- R6: An identification read (`req_read`=1) sends the command word and then clocks a 9-bit dummy word whose received bits are discarded. It then clocks an 8-bit word, sampled MSB first on rising edges, and that byte appears on `rsp_id` while `rsp_valid` is high for exactly one cycle.
- R7: `req_ready` is high only while the block is idle, and a request is taken when `req_valid` and `req_ready` are both high. `busy` is high from the acceptance until the transfer completes, and `req_ready` is low whenever `busy` is high.
- R8: `lcd_sda_oe` is 1 while a command or parameter word is being clocked. It is 0 while the dummy word and the ID word are being clocked, and it is 0 whenever chip select is high.
- R9: While `rst_n` is low, and right after it rises, `lcd_cs_n`=1, `lcd_sclk`=0, `lcd_sda_oe`=0, `busy`=0, `rsp_valid`=0 and `req_ready`=1. A reset in the middle of a transfer abandons it.
- R10: One serial half period lasts HALF = CLK_HZ/(2*SCLK_HZ) system clock cycles. `busy` falls 20*HALF+1 cycles after a write is accepted. `rsp_valid` rises 58*HALF+3 cycles after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_read | input | 1 | 1 = identification read, 0 = single word write |
| req_param | input | 1 | Write only: 1 = parameter word, 0 = command word |
| req_byte | input | 8 | Opcode or parameter byte |
| rsp_valid | output | 1 | One-cycle strobe with the read identification byte |
| rsp_id | output | 8 | Identification byte from the last read |
| busy | output | 1 | A transfer is in progress |
| lcd_sclk | output | 1 | Serial clock, idles low |
| lcd_cs_n | output | 1 | Active-low chip select, one window per word |
| lcd_sda_out | output | 1 | Outgoing serial data |
| lcd_sda_oe | output | 1 | Drive enable for the shared data line |
| lcd_sda_in | input | 1 | Incoming serial data from the shared line |

## Verification
A write is due 20*HALF+1 cycles after acceptance, when `busy` falls. A read returns `rsp_valid` at 58*HALF+3 cycles, because each of its two hand-overs between words costs one cycle. The bench counts clock edges from the edge where the request was taken and samples on the falling system edge. It requires completion at exactly that count, and it checks that `rsp_valid` is low again one cycle later. A panel model on the serial pins records each word with its bit count and checks the flag bit. It drives a recognisable pattern during the dummy word, so if the ID were taken from the wrong word, `rsp_id` would be wrong. Edge monitors measure setup, hold and the gap in system cycles against the half period.

// File: rtl/panel9_pkg.sv
package panel9_pkg;
   localparam int WORD_W = 9;
   localparam int ID_W   = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_RD_OP,
      ST_RD_SKIP,
      ST_RD_ID
   } link_state_t;

   function automatic logic [WORD_W-1:0] make_word(input logic is_arg, input logic [7:0] b);
      return {is_arg, b};
   endfunction
endpackage

// File: rtl/panel9_half_timer.sv
module panel9_half_timer #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad
         $error("HALF_DIV must be at least 1");
      end else if (HALF_DIV == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || restart) cnt <= '0;
            else if (run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/panel9_word_engine.sv
module panel9_word_engine
   import panel9_pkg::*;
#(
   parameter int HALF_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        start_nb,
   input  logic [WORD_W-1:0] start_tx,
   input  logic              start_oe,
   input  logic              sda_in,
   output logic              sclk,
   output logic              cs_n,
   output logic              sda_out,
   output logic              sda_oe,
   output logic [ID_W-1:0]   rx,
   output logic              done
);
   localparam int HW = $clog2(2 * WORD_W + 2);

   logic              active;
   logic              tick;
   logic              accept;
   logic [HW-1:0]     h;
   logic [3:0]        nb;
   logic [WORD_W-1:0] tx_sr;
   logic [ID_W-1:0]   rx_sr;
   logic [HW-1:0]     h_hold;
   logic [HW-1:0]     h_gap;

   assign accept = start && !active;
   assign h_hold = HW'({nb, 1'b0});
   assign h_gap  = h_hold + 1'b1;

   panel9_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(accept), .run(active), .tick(tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         h      <= '0;
         nb     <= 4'd0;
         tx_sr  <= '0;
         rx_sr  <= '0;
         sclk   <= 1'b0;
         cs_n   <= 1'b1;
         sda_oe <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            active <= 1'b1;
            h      <= '0;
            nb     <= start_nb;
            tx_sr  <= (start_nb == 4'(WORD_W)) ? start_tx : {start_tx[WORD_W-2:0], 1'b0};
            rx_sr  <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b0;
            sda_oe <= start_oe;
         end else if (active && tick) begin
            if (h == h_hold) begin
               cs_n   <= 1'b1;
               sda_oe <= 1'b0;
               h      <= h + 1'b1;
            end else if (h == h_gap) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else if (!h[0]) begin
               sclk  <= 1'b1;
               rx_sr <= {rx_sr[ID_W-2:0], sda_in};
               h     <= h + 1'b1;
            end else begin
               sclk  <= 1'b0;
               tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
               h     <= h + 1'b1;
            end
         end
      end
   end

   assign sda_out = tx_sr[WORD_W-1];
   assign rx      = rx_sr;
endmodule

// File: rtl/panel9_link.sv
module panel9_link
   import panel9_pkg::*;
#(
   parameter int CLK_HZ  = 8_000_000,
   parameter int SCLK_HZ = 1_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   output logic       req_ready,
   input  logic       req_read,
   input  logic       req_param,
   input  logic [7:0] req_byte,
   output logic       rsp_valid,
   output logic [7:0] rsp_id,
   output logic       busy,
   output logic       lcd_sclk,
   output logic       lcd_cs_n,
   output logic       lcd_sda_out,
   output logic       lcd_sda_oe,
   input  logic       lcd_sda_in
);
   localparam int HALF_DIV = CLK_HZ / (2 * SCLK_HZ);

   generate
      if (SCLK_HZ < 1 || HALF_DIV < 1) begin : g_chk
         $error("serial clock must be at most half the system clock");
      end
   endgenerate

   link_state_t       state;
   logic              eng_start;
   logic [3:0]        eng_nb;
   logic [WORD_W-1:0] eng_tx;
   logic              eng_oe;
   logic              eng_done;
   logic [ID_W-1:0]   eng_rx;

   always_comb begin
      eng_start = 1'b0;
      eng_nb    = 4'(WORD_W);
      eng_tx    = '0;
      eng_oe    = 1'b0;
      case (state)
         ST_IDLE: begin
            eng_start = req_valid;
            eng_tx    = make_word(!req_read && req_param, req_byte);
            eng_oe    = 1'b1;
         end
         ST_RD_OP:   eng_start = eng_done;
         ST_RD_SKIP: begin
            eng_start = eng_done;
            eng_nb    = 4'(ID_W);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            ST_IDLE:    if (req_valid) state <= req_read ? ST_RD_OP : ST_WRITE;
            ST_WRITE:   if (eng_done) state <= ST_IDLE;
            ST_RD_OP:   if (eng_done) state <= ST_RD_SKIP;
            ST_RD_SKIP: if (eng_done) state <= ST_RD_ID;
            ST_RD_ID: if (eng_done) begin
               state     <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_id    <= eng_rx;
            end
            default:    state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign busy      = (state != ST_IDLE);

   panel9_word_engine #(.HALF_DIV(HALF_DIV)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .start_nb(eng_nb),
      .start_tx(eng_tx), .start_oe(eng_oe), .sda_in(lcd_sda_in),
      .sclk(lcd_sclk), .cs_n(lcd_cs_n), .sda_out(lcd_sda_out),
      .sda_oe(lcd_sda_oe), .rx(eng_rx), .done(eng_done)
   );
endmodule

// File: rtl/panel9_link_chk.sv
module panel9_link_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic busy,
   input logic rsp_valid,
   input logic lcd_sclk,
   input logic lcd_cs_n,
   input logic lcd_sda_out,
   input logic lcd_sda_oe
);
   AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_cs_n |-> !lcd_sclk); // R4
   AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_sda_out)); // R4
   AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_cs_n) |-> !lcd_sclk); // R5
   AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_cs_n) |-> !$past(lcd_sclk)); // R5
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R6
   AST_NO_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready); // R7
   AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_sda_oe |-> !lcd_cs_n); // R8
   AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (lcd_cs_n && !lcd_sda_oe)); // R9
endmodule

bind panel9_link panel9_link_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
   .rsp_valid(rsp_valid), .lcd_sclk(lcd_sclk), .lcd_cs_n(lcd_cs_n),
   .lcd_sda_out(lcd_sda_out), .lcd_sda_oe(lcd_sda_oe)
);

// File: tb/panel9_link_test.sv
module panel9_link_test;
   localparam int H = 4;               // 8 MHz / (2 * 1 MHz)
   localparam int WR_CYC = 20 * H + 1; // R10
   localparam int RD_CYC = 58 * H + 3; // R10
   localparam logic [7:0] RD_OP = 8'h04;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_read = 1'b0, req_param = 1'b0;
   logic [7:0] req_byte = 8'h00;
   logic req_ready, rsp_valid, busy, sclk, cs_n, sda_out, sda_oe, sda_in;
   logic [7:0] rsp_id;

   always #2 clk = ~clk;

   panel9_link uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_read(req_read), .req_param(req_param), .req_byte(req_byte),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .busy(busy),
      .lcd_sclk(sclk), .lcd_cs_n(cs_n), .lcd_sda_out(sda_out),
      .lcd_sda_oe(sda_oe), .lcd_sda_in(sda_in)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // panel model
   logic [8:0] pw = '0, reply = '0;
   int pcnt = 0, phase = 0, oe_bad = 0, log_n = 0;
   logic [7:0] panel_id = 8'h00;
   logic [8:0] log_val [16];
   int log_bits [16];
   assign sda_in = reply[8];

   always @(negedge cs_n) begin
      pcnt = 0; pw = '0;
      reply = (phase == 1) ? 9'h0F3 : (phase == 2) ? {panel_id, 1'b0} : 9'h000;
   end
   always @(posedge sclk) if (!cs_n) begin
      pw = {pw[7:0], sda_out};
      pcnt++;
      if ((phase != 0) == sda_oe) oe_bad++; // R8
   end
   always @(negedge sclk) if (!cs_n) reply = reply << 1;
   always @(posedge cs_n) begin
      if (log_n < 16) begin log_val[log_n] = pw; log_bits[log_n] = pcnt; end
      log_n++;
      if (phase == 1) phase = 2;
      else if (phase == 2) phase = 0;
      else if (pcnt == 9 && pw == {1'b0, RD_OP}) phase = 1;
   end

   // edge timing monitors, sampled on falling system edge
   int cyc = 0, fall_cyc = 0, rise_cyc = 0, sfall_cyc = 0;
   int setup_bad = 0, hold_bad = 0, gap_bad = 0, stable_bad = 0;
   bit first_edge = 0, seen_rise = 0;
   logic p_cs = 1'b1, p_sclk = 1'b0, p_sda = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (p_cs && !cs_n) begin
            fall_cyc = cyc; first_edge = 1;
            if (seen_rise && cyc - rise_cyc < H) gap_bad++;
         end
         if (!p_cs && cs_n) begin
            rise_cyc = cyc; seen_rise = 1;
            if (cyc - sfall_cyc != H) hold_bad++;
         end
         if (!p_sclk && sclk && first_edge) begin
            first_edge = 0;
            if (cyc - fall_cyc != H) setup_bad++;
         end
         if (p_sclk && !sclk) sfall_cyc = cyc;
         if (p_sclk && sclk && sda_out != p_sda) stable_bad++;
         if (cs_n && sclk) stable_bad++;
      end else seen_rise = 0;
      p_cs = cs_n; p_sclk = sclk; p_sda = sda_out;
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      summary();
   end

   // {read, param, byte, id}
   localparam logic [17:0] VEC [8] = '{
      {1'b0, 1'b0, 8'h36, 8'h00},
      {1'b0, 1'b1, 8'h08, 8'h00},
      {1'b0, 1'b1, 8'hFF, 8'h00},
      {1'b1, 1'b0, RD_OP, 8'h80},
      {1'b0, 1'b0, 8'h29, 8'h00},
      {1'b1, 1'b1, RD_OP, 8'h5A},
      {1'b0, 1'b1, 8'h00, 8'h00},
      {1'b1, 1'b0, RD_OP, 8'h01}
   };

   task automatic run_req(input logic rd, input logic prm, input logic [7:0] b,
                          output int k_done, output bit ready_ok, output bit rsp_ok);
      @(negedge clk);
      req_valid = 1; req_read = rd; req_param = prm; req_byte = b;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      k_done = -1; ready_ok = 1; rsp_ok = 1;
      for (int k = 1; k < 400; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (busy && req_ready) ready_ok = 0;
         if (rsp_valid && !rd) rsp_ok = 0;
         if (!busy) begin k_done = k; break; end
      end
   endtask

   initial begin
      int k;
      bit rdy_ok, rsp_ok;
      repeat (3) @(negedge clk);
      chk(cs_n === 1 && sclk === 0 && sda_oe === 0, "R9 in reset pins", {cs_n, sclk, sda_oe}, 3'b100);
      chk(busy === 0 && rsp_valid === 0 && req_ready === 1, "R9 in reset handshake",
          {busy, rsp_valid, req_ready}, 3'b001);
      rst_n = 1;
      @(negedge clk);
      chk(cs_n === 1 && sclk === 0 && busy === 0 && req_ready === 1, "R9 after reset",
          {cs_n, sclk, busy, req_ready}, 4'b1001);

      for (int i = 0; i < 8; i++) begin
         logic rd, prm;
         logic [7:0] b, id;
         {rd, prm, b, id} = VEC[i];
         panel_id = id;
         log_n = 0;
         run_req(rd, prm, b, k, rdy_ok, rsp_ok);
         chk(rdy_ok, "R7 ready low while busy", 0, 1);
         if (!rd) begin
            chk(k == WR_CYC, "R10 write length", k, WR_CYC);
            chk(log_n == 1 && log_bits[0] == 9, "R3 one 9-clock word", log_bits[0], 9);
            chk(log_val[0] == {prm, b}, prm ? "R2 parameter word" : "R1 command word",
                log_val[0], {prm, b});
            chk(rsp_ok, "R6 no response on write", 1, 0);
         end else begin
            chk(k == RD_CYC && rsp_valid, "R10 read length", k, RD_CYC);
            chk(rsp_id == id, "R6 captured ID", rsp_id, id);
            chk(log_n == 3, "R6 three words", log_n, 3);
            chk(log_val[0] == {1'b0, RD_OP}, "R1 read opcode flag", log_val[0], {1'b0, RD_OP});
            chk(log_bits[1] == 9 && log_bits[2] == 8, "R6 dummy 9 then ID 8",
                {log_bits[1][7:0], log_bits[2][7:0]}, 16'h0908);
            @(negedge clk);
            chk(!rsp_valid, "R6 strobe one cycle", rsp_valid, 0);
         end
      end

      chk(oe_bad == 0, "R8 drive enable per word", oe_bad, 0);
      chk(stable_bad == 0, "R4 data stable while clock high", stable_bad, 0);
      chk(setup_bad == 0, "R5 setup half period", setup_bad, 0);
      chk(hold_bad == 0, "R5 hold half period", hold_bad, 0);
      chk(gap_bad == 0, "R5 gap between words", gap_bad, 0);

      // reset in the middle of a read
      @(negedge clk);
      req_valid = 1; req_read = 1; req_byte = RD_OP;
      @(negedge clk);
      req_valid = 0;
      repeat (30 * H) @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      chk(cs_n === 1 && sclk === 0 && sda_oe === 0 && busy === 0, "R9 mid-transfer reset",
          {cs_n, sclk, sda_oe, busy}, 4'b1000);
      rst_n = 1;
      phase = 0;
      @(negedge clk);
      chk(req_ready === 1 && rsp_valid === 0, "R9 ready after reset", {req_ready, rsp_valid}, 2'b10);

      // a write after the abandoned read is a clean single word
      log_n = 0;
      run_req(1'b0, 1'b1, 8'hA5, k, rdy_ok, rsp_ok);
      chk(log_n == 1 && log_val[0] == 9'h1A5, "R2 write after reset", log_val[0], 9'h1A5);
      summary();
   end
endmodule